// File: doc/BRIEF.md
# Predicted Fetch Address Generator

This block produces the next instruction fetch address for a 32-bit in-order-fetch RISC-V front end. It holds the current fetch PC in a register and, every cycle, selects the next one. The sources are, from strongest to weakest: a trap entry vector, a machine-return vector, a redirect from the back end, a predicted branch target, and the sequential address PC+4. The current PC, the same PC as the fetch address, and PC+4 are presented to the instruction cache and the instruction buffer.

Prediction combines two structures. The first is a direct-mapped target cache that maps a fetch PC to a remembered branch target. The second is a direction table of two-bit counters, indexed by the fetch PC XOR-folded with a global outcome history. The fetch stream is steered to a remembered target only when both agree: the target cache hits and the selected counter leans taken. The execute stage trains both structures after each resolved branch. It returns the branch PC, the resolved target, the actual outcome, the prediction that had been made, and the table index that had been used. The block reports a misprediction in the same cycle.

Top module: `fetch_pc_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `pc_o` equals `RESET_PC` (0x100 by default). The history register is zero, every direction counter holds the weakly not-taken value 2'b01, and every target-cache entry is invalid.
- R2: With no event, no stall and no steer, the PC advances by 4 each cycle. `fetch_addr_o` always equals `pc_o`, and `pc_plus4_o` always equals `pc_o + 4`.
- R3: When `stall_i` is high and no trap, return or redirect is present, the PC keeps its value. A stall also overrides a prediction.
- R4: `redir_valid_i` loads `redir_pc_i` into the PC on the next cycle. This happens even while stalled.
- R5: A trap has the highest priority and loads `trap_vec_i`. A machine return comes next and loads `mret_vec_i`. Both override a redirect.
- R6: `pred_idx_o` equals `pc_o[HIST_W+1:2] XOR history`. For `HIST_W` = 8, this is bits 9..2 of the PC.
- R7: When the target cache hits for `pc_o` and the counter at `pred_idx_o` has its upper bit set, `pred_taken_o` is 1 and the next PC is the stored target. Otherwise `pred_taken_o` is 0.
- R8: On each resolved branch (`upd_valid_i`), the counter at `upd_idx_i` moves one step toward the outcome. It saturates at 2'b00 and at 2'b11.
- R9: On each resolved branch, the history shifts left by one bit and takes the actual outcome into bit 0. Without a resolved branch, the history is unchanged.
- R10: A resolved taken branch writes the entry at `upd_pc_i[5:2]` with a valid bit, the tag and `upd_target_i`. The tag is `{pc[31:6], pc[1:0]}`. A lookup hits only when the entry is valid and the tag matches, so an address 64 bytes away misses.
- R11: `mispred_o` is high in the same cycle exactly when `upd_valid_i` is high and `upd_pred_i` differs from `upd_taken_i`.
- R12: A back-end redirect wins over a predicted target in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall_i | input | 1 | Hold the PC |
| trap_i | input | 1 | Trap taken |
| trap_vec_i | input | ADDR_W | Trap entry address |
| mret_i | input | 1 | Machine return |
| mret_vec_i | input | ADDR_W | Return address |
| redir_valid_i | input | 1 | Back-end redirect |
| redir_pc_i | input | ADDR_W | Redirect address |
| upd_valid_i | input | 1 | A branch resolved this cycle |
| upd_pc_i | input | ADDR_W | PC of the resolved branch |
| upd_target_i | input | ADDR_W | Resolved target |
| upd_taken_i | input | 1 | Actual outcome |
| upd_pred_i | input | 1 | Direction that was predicted |
| upd_idx_i | input | HIST_W | Direction-table index used at prediction |
| fetch_addr_o | output | ADDR_W | Address sent to the instruction cache |
| pc_o | output | ADDR_W | Current PC for the instruction buffer |
| pc_plus4_o | output | ADDR_W | Current PC plus 4 |
| pred_taken_o | output | 1 | Fetch is being steered to a predicted target |
| pred_idx_o | output | HIST_W | Direction-table index for the current PC |
| mispred_o | output | 1 | Resolved outcome differs from the prediction |

## Verification
The hardest case to reach is a chosen PC whose target-cache entry is valid and whose counter, selected under the current history, sits at a chosen value. Every training step moves the history, and so it moves the index the PC will use. The stimulus solves this in two steps. First, runs of identical outcomes pin the history at all-ones or all-zeros, so the index stops drifting. Then the training is aimed at the index the probed PC will compute, and a redirect parks the PC on that address. The redirect leaves both the history and the tables untouched. A sweep that drives every counter to saturation lets the target-cache tag alone decide, so neighbouring addresses that alias onto one entry can be compared.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  // Two-bit saturating counter step toward the resolved outcome.
  function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken && (cur != 2'b11)) begin
      nxt = cur + 2'b01;
    end else if (!taken && (cur != 2'b00)) begin
      nxt = cur - 2'b01;
    end
    return nxt;
  endfunction

  localparam logic [1:0] CNT_WEAK_NT = 2'b01;

endpackage

// File: rtl/fpg_rst_sync.sv
module fpg_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fpg_btb.sv
module fpg_btb #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] tgt_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_pc_i,
  input  logic [ADDR_W-1:0] wr_tgt_i
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return {pc[ADDR_W-1:IDX_W+2], pc[1:0]};
  endfunction

  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  rd_tag;
  logic [TAG_W-1:0]  wr_tag;
  logic [ENTRIES-1:0] vld_vec;
  logic [TAG_W-1:0]  tag_arr [ENTRIES];
  logic [ADDR_W-1:0] tgt_arr [ENTRIES];

  assign rd_idx = lk_pc_i[IDX_W+1:2];
  assign wr_idx = wr_pc_i[IDX_W+1:2];
  assign rd_tag = tag_of(lk_pc_i);
  assign wr_tag = tag_of(wr_pc_i);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              sel;
    logic              vld_q;
    logic              vld_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] tgt_q;

    assign sel = wr_en_i && (wr_idx == IDX_W'(e));

    always_comb begin
      vld_d = vld_q;
      if (sel) begin
        vld_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (sel) begin
        vld_q <= vld_d;
      end
    end

    // Payload flops carry no reset; the valid bit guards them.
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q <= wr_tag;
        tgt_q <= wr_tgt_i;
      end
    end

    assign vld_vec[e] = vld_q;
    assign tag_arr[e] = tag_q;
    assign tgt_arr[e] = tgt_q;
  end

  assign hit_o = vld_vec[rd_idx] && (tag_arr[rd_idx] == rd_tag);
  assign tgt_o = tgt_arr[rd_idx];

  // R10
  wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> vld_vec[$past(wr_idx)] && (tag_arr[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/fpg_gshare.sv
module fpg_gshare
  import fpg_pkg::*;
#(
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] lk_bits_i,
  output logic [HIST_W-1:0] idx_o,
  output logic              taken_o,
  input  logic              upd_valid_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] upd_idx_i
);

  localparam int unsigned ENTRIES = 1 << HIST_W;

  logic [HIST_W-1:0] ghr_q;
  logic [HIST_W-1:0] ghr_d;
  logic [1:0]        cnt_arr [ENTRIES];

  always_comb begin
    ghr_d = ghr_q;
    if (upd_valid_i) begin
      ghr_d = {ghr_q[HIST_W-2:0], upd_taken_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr_q <= '0;
    end else if (upd_valid_i) begin
      ghr_q <= ghr_d;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
    logic       en;
    logic [1:0] cnt_q;
    logic [1:0] cnt_d;

    assign en = upd_valid_i && (upd_idx_i == HIST_W'(e));

    always_comb begin
      cnt_d = sat_step(cnt_q, upd_taken_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= CNT_WEAK_NT;
      end else if (en) begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_arr[e] = cnt_q;
  end

  assign idx_o   = lk_bits_i ^ ghr_q;
  assign taken_o = cnt_arr[idx_o][1];

  // R9
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_i |=> (ghr_q[0] == $past(upd_taken_i)) &&
                    (ghr_q[HIST_W-1:1] == $past(ghr_q[HIST_W-2:0])));

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid_i |=> $stable(ghr_q));

  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && upd_taken_i && (cnt_arr[upd_idx_i] == 2'b11))
      |=> cnt_arr[$past(upd_idx_i)] == 2'b11);

  // R8
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && !upd_taken_i && (cnt_arr[upd_idx_i] == 2'b00))
      |=> cnt_arr[$past(upd_idx_i)] == 2'b00);

endmodule

// File: rtl/fpg_pc_mux.sv
module fpg_pc_mux #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              trap_i,
  input  logic [ADDR_W-1:0] trap_vec_i,
  input  logic              mret_i,
  input  logic [ADDR_W-1:0] mret_vec_i,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] redir_pc_i,
  input  logic              steer_i,
  input  logic [ADDR_W-1:0] steer_tgt_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  output logic [ADDR_W-1:0] next_pc_o
);

  always_comb begin
    if (trap_i) begin
      next_pc_o = trap_vec_i;
    end else if (mret_i) begin
      next_pc_o = mret_vec_i;
    end else if (redir_i) begin
      next_pc_o = redir_pc_i;
    end else if (steer_i) begin
      next_pc_o = steer_tgt_i;
    end else begin
      next_pc_o = seq_pc_i;
    end
  end

endmodule

// File: rtl/fetch_pc_gen.sv
module fetch_pc_gen #(
  parameter int unsigned      ADDR_W      = 32,
  parameter int unsigned      BTB_ENTRIES = 16,
  parameter int unsigned      HIST_W      = 8,
  parameter logic [ADDR_W-1:0] RESET_PC   = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              trap_i,
  input  logic [ADDR_W-1:0] trap_vec_i,
  input  logic              mret_i,
  input  logic [ADDR_W-1:0] mret_vec_i,
  input  logic              redir_valid_i,
  input  logic [ADDR_W-1:0] redir_pc_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_taken_i,
  input  logic              upd_pred_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] pc_plus4_o,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_idx_o,
  output logic              mispred_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic              rst_n_s;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] pc_seq;
  logic              pc_en;
  logic              btb_hit;
  logic [ADDR_W-1:0] btb_tgt;
  logic              dir_taken;
  logic              steer;
  logic              btb_wr;

  fpg_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  assign pc_seq = pc_q + STEP;
  assign btb_wr = upd_valid_i && upd_taken_i;

  fpg_btb #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (BTB_ENTRIES)
  ) u_btb (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lk_pc_i  (pc_q),
    .hit_o    (btb_hit),
    .tgt_o    (btb_tgt),
    .wr_en_i  (btb_wr),
    .wr_pc_i  (upd_pc_i),
    .wr_tgt_i (upd_target_i)
  );

  fpg_gshare #(
    .HIST_W (HIST_W)
  ) u_gshare (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .lk_bits_i   (pc_q[HIST_W+1:2]),
    .idx_o       (pred_idx_o),
    .taken_o     (dir_taken),
    .upd_valid_i (upd_valid_i),
    .upd_taken_i (upd_taken_i),
    .upd_idx_i   (upd_idx_i)
  );

  assign steer = btb_hit && dir_taken;

  fpg_pc_mux #(
    .ADDR_W (ADDR_W)
  ) u_mux (
    .trap_i      (trap_i),
    .trap_vec_i  (trap_vec_i),
    .mret_i      (mret_i),
    .mret_vec_i  (mret_vec_i),
    .redir_i     (redir_valid_i),
    .redir_pc_i  (redir_pc_i),
    .steer_i     (steer),
    .steer_tgt_i (btb_tgt),
    .seq_pc_i    (pc_seq),
    .next_pc_o   (pc_d)
  );

  assign pc_en = !stall_i || trap_i || mret_i || redir_valid_i;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign fetch_addr_o = pc_q;
  assign pc_o         = pc_q;
  assign pc_plus4_o   = pc_seq;
  assign pred_taken_o = steer;
  assign mispred_o    = upd_valid_i && (upd_pred_i != upd_taken_i);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stall_i && !trap_i && !mret_i && !redir_valid_i && !pred_taken_o)
      |=> pc_q == $past(pc_q) + STEP);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stall_i && !trap_i && !mret_i && !redir_valid_i) |=> $stable(pc_q));

  // R4
  redir_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (redir_valid_i && !trap_i && !mret_i) |=> pc_q == $past(redir_pc_i));

  // R5
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    trap_i |=> pc_q == $past(trap_vec_i));

  // R5
  ret_second_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mret_i && !trap_i) |=> pc_q == $past(mret_vec_i));

  // R7
  steer_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pred_taken_o |-> btb_hit);

  // R7
  steer_target_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pred_taken_o && !stall_i && !trap_i && !mret_i && !redir_valid_i)
      |=> pc_q == $past(btb_tgt));

  // R11
  no_update_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !upd_valid_i |-> !mispred_o);

  // R12
  redir_over_pred_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pred_taken_o && redir_valid_i && !trap_i && !mret_i)
      |=> pc_q == $past(redir_pc_i));

endmodule

// File: tb/test_fetch_pc_gen.sv
module test_fetch_pc_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall, trap, mret, redir, upd_v, upd_t, upd_p;
  logic [31:0] trap_vec, mret_vec, redir_pc, upd_pc, upd_tgt;
  logic [7:0]  upd_idx;
  logic [31:0] fetch_addr_o, pc_o, pc_plus4_o;
  logic        pred_taken_o, mispred_o;
  logic [7:0]  pred_idx_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Bench-side model state, derived from the requirements.
  logic [31:0] pc_m;
  logic [7:0]  ghr_m;
  logic [1:0]  cnt_m   [256];
  logic        btbv_m  [16];
  logic [27:0] btag_m  [16];
  logic [31:0] btgt_m  [16];

  always #10 clk = ~clk;

  fetch_pc_gen i_fetch_pc_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall),
    .trap_i        (trap),
    .trap_vec_i    (trap_vec),
    .mret_i        (mret),
    .mret_vec_i    (mret_vec),
    .redir_valid_i (redir),
    .redir_pc_i    (redir_pc),
    .upd_valid_i   (upd_v),
    .upd_pc_i      (upd_pc),
    .upd_target_i  (upd_tgt),
    .upd_taken_i   (upd_t),
    .upd_pred_i    (upd_p),
    .upd_idx_i     (upd_idx),
    .fetch_addr_o  (fetch_addr_o),
    .pc_o          (pc_o),
    .pc_plus4_o    (pc_plus4_o),
    .pred_taken_o  (pred_taken_o),
    .pred_idx_o    (pred_idx_o),
    .mispred_o     (mispred_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    stall = 1'b0; trap = 1'b0; mret = 1'b0; redir = 1'b0;
    upd_v = 1'b0; upd_t = 1'b0; upd_p = 1'b0;
    trap_vec = '0; mret_vec = '0; redir_pc = '0;
    upd_pc = '0; upd_tgt = '0; upd_idx = '0;
  endtask

  // One cycle: check outputs against the model, then advance model and DUT.
  task automatic tick(input string tag);
    logic [31:0] nxt;
    logic [7:0]  mi;
    logic [3:0]  be;
    logic        steer;
    #1;
    mi    = pc_m[9:2] ^ ghr_m;
    be    = pc_m[5:2];
    steer = btbv_m[be] && (btag_m[be] == {pc_m[31:6], pc_m[1:0]}) && cnt_m[mi][1];
    chk(pc_o == pc_m, tag, "pc", pc_o, pc_m);
    chk(fetch_addr_o == pc_m, tag, "fetch_addr", fetch_addr_o, pc_m);
    chk(pc_plus4_o == pc_m + 32'd4, tag, "pc_plus4", pc_plus4_o, pc_m + 32'd4);
    chk(pred_idx_o == mi, tag, "pred_idx", 32'(pred_idx_o), 32'(mi));
    chk(pred_taken_o == steer, tag, "pred_taken", 32'(pred_taken_o), 32'(steer));
    chk(mispred_o == (upd_v && (upd_p != upd_t)), tag, "mispred",
        32'(mispred_o), 32'(upd_v && (upd_p != upd_t)));
    if (trap)        nxt = trap_vec;
    else if (mret)   nxt = mret_vec;
    else if (redir)  nxt = redir_pc;
    else if (stall)  nxt = pc_m;
    else if (steer)  nxt = btgt_m[be];
    else             nxt = pc_m + 32'd4;
    @(posedge clk);
    if (upd_v) begin
      if (upd_t && cnt_m[upd_idx] != 2'b11) cnt_m[upd_idx] = cnt_m[upd_idx] + 2'b01;
      if (!upd_t && cnt_m[upd_idx] != 2'b00) cnt_m[upd_idx] = cnt_m[upd_idx] - 2'b01;
      ghr_m = {ghr_m[6:0], upd_t};
      if (upd_t) begin
        btbv_m[upd_pc[5:2]] = 1'b1;
        btag_m[upd_pc[5:2]] = {upd_pc[31:6], upd_pc[1:0]};
        btgt_m[upd_pc[5:2]] = upd_tgt;
      end
    end
    pc_m = nxt;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic train(input logic [31:0] p, input logic [31:0] t, input logic tk,
                       input logic pr, input logic [7:0] ix, input string tag);
    upd_v = 1'b1; upd_pc = p; upd_tgt = t; upd_t = tk; upd_p = pr; upd_idx = ix;
    tick(tag);
  endtask

  task automatic go_to(input logic [31:0] a, input string tag);
    redir = 1'b1; redir_pc = a;
    tick(tag);
  endtask

  function automatic logic [7:0] idx_after(input logic [31:0] p, input logic tk);
    return p[9:2] ^ {ghr_m[6:0], tk};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    // R1: reset state visible at the ports
    chk(pc_o == 32'h100, "R1", "pc", pc_o, 32'h100);
    chk(pc_plus4_o == 32'h104, "R1", "pc_plus4", pc_plus4_o, 32'h104);
    chk(pred_idx_o == 8'h40, "R1", "pred_idx", 32'(pred_idx_o), 32'h40);
    chk(pred_taken_o == 1'b0, "R1", "pred_taken", 32'(pred_taken_o), 32'h0);
    chk(mispred_o == 1'b0, "R1", "mispred", 32'(mispred_o), 32'h0);
    pc_m  = 32'h100;
    ghr_m = '0;
    for (int i = 0; i < 256; i++) cnt_m[i] = 2'b01;
    for (int i = 0; i < 16; i++) begin
      btbv_m[i] = 1'b0; btag_m[i] = '0; btgt_m[i] = '0;
    end

    repeat (4) tick("R2 sequential");
    for (int i = 0; i < 3; i++) begin
      stall = 1'b1;
      tick("R3 stall hold");
    end
    go_to(32'h1000, "R4 redirect");
    tick("R4 landed");
    trap = 1'b1; trap_vec = 32'h0000_0800; mret = 1'b1; mret_vec = 32'h0000_0C00;
    redir = 1'b1; redir_pc = 32'h0000_0E00;
    tick("R5 trap first");
    mret = 1'b1; mret_vec = 32'h0000_0C00; redir = 1'b1; redir_pc = 32'h0000_0E00;
    tick("R5 return second");
    stall = 1'b1; redir = 1'b1; redir_pc = 32'h0000_1800;
    tick("R4 redirect under stall");
    tick("R4 landed under stall");

    // R8: one taken step from the reset value already predicts taken.
    train(32'h2000, 32'h2400, 1'b1, 1'b0, idx_after(32'h2000, 1'b1), "R8 first taken R11");
    go_to(32'h2000, "R4 park");
    tick("R7 steer after one step");
    tick("R7 target reached");

    // R6/R9/R11: varied history pattern.
    for (int k = 0; k < 12; k++) begin
      train(32'hF000_0000, 32'h0000_0040, (k % 3) == 0, k[0], 8'(k * 29),
            "R9 history R6 index R11 flag");
    end

    // R8: pin history at all-ones, then saturate every counter upward.
    for (int k = 0; k < 8; k++) train(32'hF000_0000, 32'h40, 1'b1, 1'b1, 8'hFF, "R9 fill ones");
    for (int i = 0; i < 256; i++) begin
      for (int r = 0; r < 3; r++) begin
        train(32'hF000_0000, 32'h40, 1'b1, 1'b1, 8'(i), "R8 saturate up");
      end
    end

    // R10: fill each target-cache entry.
    for (int k = 0; k < 16; k++) begin
      train(32'h4000 + 32'(4 * k), 32'h9000 + 32'(64 * k), 1'b1, 1'b1, 8'h00, "R10 fill");
    end
    for (int k = 0; k < 16; k++) begin
      go_to(32'h4000 + 32'(4 * k), "R4 park");
      tick("R7 hit and taken");
      tick("R7 at target");
      go_to(32'h4040 + 32'(4 * k), "R4 park alias");
      tick("R10 alias tag misses");
      tick("R10 sequential after miss");
      go_to(32'h4000 + 32'(4 * k), "R4 park");
      redir = 1'b1; redir_pc = 32'h7000;
      tick("R12 redirect beats prediction");
      tick("R12 landed");
      go_to(32'h4000 + 32'(4 * k), "R4 park");
      stall = 1'b1;
      tick("R3 stall beats prediction");
      tick("R3 released");
    end

    // R8: pin history at zero, walk the counter for 0x4000 down.
    for (int k = 0; k < 8; k++) train(32'hF000_0000, 32'h40, 1'b0, 1'b1, 8'h80, "R9 fill zeros");
    train(32'hF000_0000, 32'h40, 1'b0, 1'b1, 8'h00, "R8 one step down");
    go_to(32'h4000, "R4 park");
    tick("R8 hysteresis still taken");
    for (int k = 0; k < 3; k++) train(32'hF000_0000, 32'h40, 1'b0, 1'b0, 8'h00, "R8 down");
    go_to(32'h4000, "R4 park");
    tick("R8 saturated low not taken");
    tick("R8 sequential");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule